// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a data cache controller placed between a processor load/store port and a slower main-memory port. The main store is direct-mapped: every line address has exactly one home slot, so two addresses that share an index push each other out. A small fully associative side buffer catches the lines that are pushed out. If a later lookup misses the main store but finds its line in the side buffer, the two lines trade places in one cycle and the retried request then hits.

The policy is write-back. A write hit only marks the line dirty, and memory is brought up to date when a dirty line finally drops out of the side buffer. A write to a line that is present in neither store is sent straight to memory as a single word and allocates nothing. A read that misses both stores stalls the processor. The controller then writes back the oldest side-buffer entry if it is dirty and the slot is needed, moves the outgoing main line into the side buffer, and fetches the new line as a burst of four words.

The processor keeps `cpu_req` and its address and data steady until `cpu_ready` is high. The memory port moves one word per `mem_valid`/`mem_ready` handshake, and read data on `mem_rdata` is taken in the handshake cycle.

Top module: `vcache_top`

## Requirements
- R1: The word address splits into offset bits [1:0], index bits [7:2] (64 lines) and tag bits [15:8]. A read that hits the main store raises `cpu_ready` in the same cycle as the request, shows the addressed word on `cpu_rdata`, and starts no memory transfer.
- R2: A write that hits the main store raises `cpu_ready` in the same cycle, updates that word and marks the line dirty. It starts no memory transfer.
- R3: A clean line is never written to memory. A dirty line is written to memory only when it leaves the side buffer, as four word writes at offsets 0,1,2,3 carrying the latest data.
- R4: A request that misses the main store but matches a side-buffer entry swaps the two lines in one cycle with `cpu_ready` low. The line that leaves the main store takes the vacated slot, and the retried request completes on the next cycle.
- R5: A read that misses both stores keeps `cpu_ready` low while the line is fetched as four reads at offsets 0,1,2,3 of that line. The request then completes as a hit.
- R6: A write that misses both stores issues exactly one memory write of that word and raises `cpu_ready` in the cycle of its handshake. It allocates no line, so a later read of that address misses.
- R7: Side-buffer slots are refilled in round-robin order. When the slot about to be refilled holds a dirty line, its four-word write-back finishes before any word of the new line is fetched.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R9: Reset clears every valid and dirty bit in both stores. While idle, and after reset, `cpu_ready` and `mem_valid` are low, and the first access to any address misses.
- R10: A read always returns the value most recently written to its address, across swaps, write-backs and write-around writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_ready` is high on a load |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken in the handshake cycle |

## Verification
The bench drives a run of distinct tags into a single index until the side buffer wraps. This covers the case where a dirty oldest entry must be flushed before a fill. A design that skipped that step would lose data, and one that flushed clean lines would show an extra write count. Side-buffer hits are checked for a completion exactly one cycle later, which catches a swap that drops the displaced line or gets the dirty bit wrong. A write-around followed by a read of the same word checks that nothing was allocated and that the stale copy in memory was replaced. A long random phase over a few indices, with memory back-pressure, compares every returned word against a behavioural memory image.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WB    = 2'd1,
    ST_EVICT = 2'd2,
    ST_FILL  = 2'd3
  } vc_state_e;
endpackage

// File: rtl/vcache_victim.sv
module vcache_victim #(
  parameter int LA_W    = 14,
  parameter int LINE_W  = 128,
  parameter int ENTRIES = 4,
  parameter int VS_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   lk_la,
  output logic              hit,
  output logic [VS_W-1:0]   hit_slot,
  input  logic [VS_W-1:0]   rd_slot,
  output logic [LA_W-1:0]   rd_la,
  output logic [LINE_W-1:0] rd_line,
  output logic              rd_valid,
  output logic              rd_dirty,
  input  logic              ld_en,
  input  logic [VS_W-1:0]   ld_slot,
  input  logic [LA_W-1:0]   ld_la,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              ld_dirty,
  input  logic              clr_en,
  input  logic [VS_W-1:0]   clr_slot
);
  logic [ENTRIES-1:0] vld_q, drt_q, match;
  logic [LA_W-1:0]    la_q   [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];

  // one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (la_q[g] == lk_la);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_slot = VS_W'(i);
  end

  assign hit      = |match;
  assign rd_la    = la_q[rd_slot];
  assign rd_line  = line_q[rd_slot];
  assign rd_valid = vld_q[rd_slot];
  assign rd_dirty = drt_q[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else begin
      if (ld_en) begin
        vld_q[ld_slot] <= 1'b1;
        drt_q[ld_slot] <= ld_dirty;
      end
      if (clr_en) begin
        vld_q[clr_slot] <= 1'b0;
        drt_q[clr_slot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      la_q[ld_slot]   <= ld_la;
      line_q[ld_slot] <= ld_line;
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vcache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 64,
  parameter int WORDS  = 4,
  parameter int VICT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;
  localparam int VS_W   = $clog2(VICT);
  localparam logic [OFF_W-1:0] LAST_W = OFF_W'(WORDS - 1);
  localparam logic [VS_W-1:0]  LAST_V = VS_W'(VICT - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [LA_W-1:0]  la;
  assign tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign idx = cpu_addr[OFF_W +: IDX_W];
  assign off = cpu_addr[OFF_W-1:0];
  assign la  = cpu_addr[ADDR_W-1:OFF_W];

  // main direct-mapped store
  logic [LINES-1:0]  mvalid, mdirty;
  logic [TAG_W-1:0]  mtag  [LINES];
  logic [LINE_W-1:0] mline [LINES];
  logic              m_hit;
  assign m_hit     = mvalid[idx] && (mtag[idx] == tag);
  assign cpu_rdata = mline[idx][off*DATA_W +: DATA_W];

  vc_state_e       st, st_nxt;
  logic [OFF_W-1:0] cnt, cnt_nxt;
  logic [VS_W-1:0]  ptr, ptr_nxt;

  logic              v_hit, v_rd_valid, v_rd_dirty, v_ld_en, v_ld_dirty, v_clr_en;
  logic [VS_W-1:0]   v_hit_slot, v_rd_slot, v_ld_slot, v_clr_slot;
  logic [LA_W-1:0]   v_rd_la, v_ld_la;
  logic [LINE_W-1:0] v_rd_line, v_ld_line;
  logic              m_wr_word, m_fill_word, m_fill_done, m_swap, m_evict;

  vcache_victim #(.LA_W(LA_W), .LINE_W(LINE_W), .ENTRIES(VICT), .VS_W(VS_W)) i_victim (
    .clk(clk), .rst_n(rst_sync_n), .lk_la(la), .hit(v_hit), .hit_slot(v_hit_slot),
    .rd_slot(v_rd_slot), .rd_la(v_rd_la), .rd_line(v_rd_line), .rd_valid(v_rd_valid),
    .rd_dirty(v_rd_dirty), .ld_en(v_ld_en), .ld_slot(v_ld_slot), .ld_la(v_ld_la),
    .ld_line(v_ld_line), .ld_dirty(v_ld_dirty), .clr_en(v_clr_en), .clr_slot(v_clr_slot)
  );

  // next-state and output decode
  always_comb begin
    st_nxt = st; cnt_nxt = cnt; ptr_nxt = ptr;
    cpu_ready = 1'b0; mem_valid = 1'b0; mem_we = 1'b0;
    mem_addr = cpu_addr; mem_wdata = cpu_wdata;
    v_rd_slot = ptr; v_ld_en = 1'b0; v_ld_slot = ptr; v_clr_en = 1'b0; v_clr_slot = ptr;
    v_ld_la = {mtag[idx], idx}; v_ld_line = mline[idx]; v_ld_dirty = mdirty[idx];
    m_wr_word = 1'b0; m_fill_word = 1'b0; m_fill_done = 1'b0; m_swap = 1'b0; m_evict = 1'b0;
    unique case (st)
      ST_IDLE: if (cpu_req) begin
        if (m_hit) begin
          cpu_ready = 1'b1;
          m_wr_word = cpu_we;
        end else if (v_hit) begin
          v_rd_slot  = v_hit_slot;
          v_ld_slot  = v_hit_slot;
          v_clr_slot = v_hit_slot;
          m_swap     = 1'b1;
          v_ld_en    = mvalid[idx];
          v_clr_en   = !mvalid[idx];
        end else if (cpu_we) begin
          mem_valid = 1'b1;
          mem_we    = 1'b1;
          cpu_ready = mem_ready;
        end else begin
          cnt_nxt = '0;
          st_nxt  = (mvalid[idx] && v_rd_valid && v_rd_dirty) ? ST_WB : ST_EVICT;
        end
      end
      ST_WB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {v_rd_la, cnt};
        mem_wdata = v_rd_line[cnt*DATA_W +: DATA_W];
        if (mem_ready) begin
          cnt_nxt = cnt + 1'b1;
          if (cnt == LAST_W) begin
            v_clr_en = 1'b1;
            st_nxt   = ST_EVICT;
          end
        end
      end
      ST_EVICT: begin
        st_nxt = ST_FILL;
        if (mvalid[idx]) begin
          m_evict = 1'b1;
          v_ld_en = 1'b1;
          ptr_nxt = (ptr == LAST_V) ? '0 : ptr + 1'b1;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {la, cnt};
        if (mem_ready) begin
          m_fill_word = 1'b1;
          cnt_nxt     = cnt + 1'b1;
          if (cnt == LAST_W) begin
            m_fill_done = 1'b1;
            st_nxt      = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      ptr <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
      ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mvalid <= '0;
      mdirty <= '0;
    end else begin
      if (m_wr_word) mdirty[idx] <= 1'b1;
      if (m_swap) begin
        mvalid[idx] <= 1'b1;
        mdirty[idx] <= v_rd_dirty;
      end
      if (m_evict) mvalid[idx] <= 1'b0;
      if (m_fill_done) begin
        mvalid[idx] <= 1'b1;
        mdirty[idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (m_wr_word)   mline[idx][off*DATA_W +: DATA_W] <= cpu_wdata;
    if (m_fill_word) mline[idx][cnt*DATA_W +: DATA_W] <= mem_rdata;
    if (m_swap) begin
      mline[idx] <= v_rd_line;
      mtag[idx]  <= v_rd_la[LA_W-1 -: TAG_W];
    end
    if (m_fill_done) mtag[idx] <= tag;
  end
endmodule

// File: rtl/vcache_chk.sv
module vcache_chk
  import vcache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input vc_state_e         st,
  input logic              v_rd_valid,
  input logic              v_rd_dirty,
  input logic              m_hit
);
  // R1: completion only for a live request
  p_ready_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R1 and R2: a hit in the idle state makes no memory traffic
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cpu_req && m_hit) |-> !mem_valid);

  // R3: only a valid dirty slot is ever written back
  p_wb_dirty_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB) |-> (v_rd_valid && v_rd_dirty));

  // R5: processor stays stalled while a line moves
  p_stall_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !cpu_ready);

  // R6: memory traffic from the idle state is a write-around store
  p_around_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && mem_valid) |-> (mem_we && cpu_we && !m_hit));

  // R8: a stalled memory request stays put
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind vcache_top vcache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .st(st), .v_rd_valid(v_rd_valid), .v_rd_dirty(v_rd_dirty), .m_hit(m_hit)
);

// File: tb/test_vcache_top.sv
`timescale 1ns/100ps
module test_vcache_top;
  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [15:0] cpu_addr, mem_addr;
  logic [31:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic        mem_valid, mem_ready, mem_we;

  vcache_top i_vcache_top (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // backing memory and architectural image, addresses below 4096
  logic [31:0] bmem [4096];
  logic [31:0] arch [4096];
  assign mem_rdata = bmem[mem_addr[11:0]];

  int nchk = 0, nerr = 0, cycles = 0;
  int exp_wr = 0, exp_rd = 0, obs_wr = 0, obs_rd = 0;

  // behavioural residency model
  int m_tag [64];
  bit m_val [64];
  bit m_drt [64];
  int v_la  [4];
  bit v_val [4];
  bit v_drt [4];
  int v_ptr;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // code: 0 = not ready first cycle, 1 = ready, 2 = ready equals mem_ready; swp = side-buffer hit
  task automatic predict(input bit we, input logic [15:0] a, output int code, output bit swp);
    int idx, tg, la, k;
    idx = int'(a[7:2]); tg = int'(a[15:8]); la = int'(a[15:2]);
    swp = 1'b0; k = -1;
    for (int i = 0; i < 4; i++) if (v_val[i] && v_la[i] == la) k = i;
    if (m_val[idx] && m_tag[idx] == tg) begin
      code = 1;
      if (we) m_drt[idx] = 1'b1;
    end else if (k >= 0) begin
      int ol; bit od, ov;
      code = 0; swp = 1'b1;
      ol = m_tag[idx] * 64 + idx; od = m_drt[idx]; ov = m_val[idx];
      m_tag[idx] = tg; m_drt[idx] = v_drt[k]; m_val[idx] = 1'b1;
      if (ov) begin v_la[k] = ol; v_drt[k] = od; v_val[k] = 1'b1; end
      else begin v_val[k] = 1'b0; v_drt[k] = 1'b0; end
      if (we) m_drt[idx] = 1'b1;
    end else if (we) begin
      code = 2;
      exp_wr += 1;
    end else begin
      code = 0;
      if (m_val[idx]) begin
        if (v_val[v_ptr] && v_drt[v_ptr]) exp_wr += 4;
        v_la[v_ptr] = m_tag[idx] * 64 + idx; v_drt[v_ptr] = m_drt[idx]; v_val[v_ptr] = 1'b1;
        v_ptr = (v_ptr + 1) % 4;
      end
      m_tag[idx] = tg; m_val[idx] = 1'b1; m_drt[idx] = 1'b0;
      exp_rd += 4;
    end
  endtask

  task automatic do_req(input bit we, input logic [15:0] a, input logic [31:0] d, input int stall_pct);
    int code, n, bwr, brd;
    bit swp, done, pv;
    logic [15:0] pa;
    predict(we, a, code, swp);
    if (we) arch[a[11:0]] = d;
    n = 0; done = 1'b0; bwr = 0; brd = 0; pv = 1'b0; pa = '0;
    while (!done) begin
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      mem_ready = ($urandom_range(0, 99) >= stall_pct);
      #1;
      if (pv) chk(mem_valid && mem_addr == pa, "R8 held memory request", mem_addr, pa);
      pv = mem_valid && !mem_ready; pa = mem_addr;
      if (n == 0) begin
        if (code == 1) chk(cpu_ready == 1'b1, "R1/R2 hit same-cycle ready", cpu_ready, 1);
        else if (code == 2) chk(cpu_ready == mem_ready, "R6 write-around ready", cpu_ready, mem_ready);
        else chk(cpu_ready == 1'b0, "R5/R9 miss stalls", cpu_ready, 0);
      end
      if (swp && n == 1) chk(cpu_ready == 1'b1, "R4 swap then hit", cpu_ready, 1);
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          chk(mem_wdata == arch[mem_addr[11:0]], "R3 write-back data", mem_wdata, arch[mem_addr[11:0]]);
          if (!we) begin
            chk(mem_addr[1:0] == 2'(bwr), "R3 write-back order", 32'(mem_addr[1:0]), bwr % 4);
            chk(brd == 0, "R7 write-back before fill", brd, 0);
            bwr++;
          end
          bmem[mem_addr[11:0]] = mem_wdata;
          obs_wr++;
        end else begin
          chk(mem_addr[1:0] == 2'(brd) && mem_addr[15:2] == a[15:2], "R5 fill address",
              32'(mem_addr), 32'({a[15:2], 2'(brd)}));
          brd++;
          obs_rd++;
        end
      end
      if (cpu_ready) begin
        done = 1'b1;
        if (!we) chk(cpu_rdata == arch[a[11:0]], "R10 read data", cpu_rdata, arch[a[11:0]]);
        chk(obs_wr == exp_wr, "R3/R7 memory write count", obs_wr, exp_wr);
        chk(obs_rd == exp_rd, "R5 memory read count", obs_rd, exp_rd);
      end
      n++;
      if (n > 300 && !done) begin
        chk(1'b0, "request watchdog", n, 300);
        done = 1'b1;
      end
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      cpu_req = 1'b0; mem_ready = 1'b1;
      #1;
      chk(!cpu_ready && !mem_valid, "R9 idle outputs quiet", {cpu_ready, mem_valid}, 0);
    end
  endtask

  function automatic logic [15:0] mk(input int tg, input int ix, input int of);
    return 16'(tg * 256 + ix * 4 + of);
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A_0000;
      arch[i] = bmem[i];
    end
    for (int i = 0; i < 64; i++) begin m_val[i] = 0; m_drt[i] = 0; m_tag[i] = 0; end
    for (int i = 0; i < 4; i++) begin v_val[i] = 0; v_drt[i] = 0; v_la[i] = 0; end
    v_ptr = 0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!cpu_ready && !mem_valid, "R9 reset outputs", {cpu_ready, mem_valid}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // basic miss, hit, write hit
    do_req(0, mk(0, 4, 0), 0, 0);
    do_req(0, mk(0, 4, 3), 0, 30);
    do_req(1, mk(0, 4, 1), 32'hCAFE_0001, 0);
    do_req(0, mk(0, 4, 1), 0, 0);

    // conflict chain on one index, dirtying some lines, wraps the side buffer
    for (int t = 1; t <= 7; t++) begin
      do_req(0, mk(t, 9, 0), 0, 20);
      if (t % 2 == 1) do_req(1, mk(t, 9, t % 4), 32'hD000_0000 + 32'(t), 0);
    end
    // bring lines back from the side buffer
    for (int t = 7; t >= 3; t--) do_req(0, mk(t, 9, 2), 0, 20);
    do_req(1, mk(4, 9, 3), 32'hBEEF_0004, 0);
    do_req(0, mk(6, 9, 3), 0, 0);

    // write-around then read of the same word
    do_req(1, mk(11, 20, 2), 32'h1234_5678, 50);
    do_req(0, mk(11, 20, 2), 0, 10);
    idle(3);

    // random mix over a few indices and tags
    for (int i = 0; i < 3000; i++) begin
      do_req(1'($urandom_range(0, 2) == 0), mk($urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 3)),
             $urandom, 25);
      if ($urandom_range(0, 9) == 0) idle(1);
    end
    summary();
  end
endmodule